// File: doc/BRIEF.md
# DDR video word deinterleaver

This block takes a 10-bit single-ended video bus that carries a new word on every edge of a half-rate pixel clock. It registers one word on each rising edge and one on each falling edge. It then presents a chroma/luma pair on a 20-bit output once per clock period. The incoming words rotate through blue-difference chroma, luma, red-difference chroma, luma. The block therefore tracks two phases. The first is which clock edge carries the chroma word. The second is whether the current chroma sample is Cb or Cr.

Both phases are set by a timing-reference preamble. The preamble is three consecutive words: all-ones, then zero, then zero. The block checks for it on the merged word stream, so it works whichever edge the preamble lands on. It emits no valid pairs until a preamble has been seen. A later preamble realigns both phases, so the output recovers from a slip of one word.

The mode enable is high only while the serial link runs at its 3 Gb/s rate. While the enable is low, the block's valid output stays low and the block forgets its alignment. In that mode the plain single-edge path carries the video.

Top module: `ddr_yc_deinterleave`

## Requirements
- R1: While rst_ni is low and right after it is released, valid_o, cr_o, y_o and c_o are all 0.
- R2: Each word sampled on a rising edge and each word sampled on a falling edge reaches the output. Neither is dropped or repeated.
- R3: The stream Cb0, Y0, Cr0, Y1, Cb1, Y2, ... produces the output pairs (c_o, y_o) = (Cb0,Y0), (Cr0,Y1), (Cb1,Y2), (Cr1,Y3), ... in that order.
- R4: cr_o is 0 for a Cb pair and 1 for a Cr pair. It alternates on every clock while pairs are valid, except at a realignment.
- R5: If the preamble word 0x3FF is sampled on a rising edge, chroma is taken on rising edges. The luma word is the one on the falling edge that follows. The pair whose chroma word is the final 0x000 of the preamble is a reference pair. The pair after it carries Cb (cr_o = 0).
- R6: If the preamble word 0x3FF is sampled on a falling edge, chroma is taken on falling edges. The luma word is the one on the rising edge that follows. The pair after the reference pair carries Cb.
- R7: After reset, valid_o stays low until a preamble has been seen. On the first lock, the reference pair is not marked valid. The first valid pair is Cb0/Y0.
- R8: If a preamble arrives while the block is locked, it overrides the current alignment. Every pair after the new reference pair is correct. After a one-word slip, the first correct pair appears within five output pairs of the start of the slip.
- R9: If ddr_en_i is low at a rising edge, valid_o is 0 after that edge. Once the enable returns high, valid_o stays low until a new preamble has been seen.
- R10: While locked and enabled, valid_o is high on every clock. That gives one pair per clock period, on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Half-rate pixel clock; data is sampled on both edges |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ddr_en_i | input | 1 | High while the link runs in double-edge mode |
| data_i | input | 10 | Interleaved video word bus |
| y_o | output | 10 | Luma word of the current pair |
| c_o | output | 10 | Chroma word of the current pair |
| cr_o | output | 1 | Chroma type: 0 = Cb, 1 = Cr |
| valid_o | output | 1 | High for each clock that carries a valid pair |

## Verification
The bench tests a preamble whose first word falls on a rising edge and one whose first word falls on a falling edge. A design that picks the wrong edge for chroma fails both. It pairs luma with the wrong chroma word, or shifts the rotation by a whole word. The bench also slips the stream by one word while the block is locked. A design that only aligns at start-up, or that ignores a preamble once locked, then emits swapped pairs indefinitely. The bench drops the enable in the middle of a stream and restarts video without a preamble. A design that keeps its lock across a mode change then emits pairs with an unknown Cb/Cr phase.

// File: rtl/ddr_yc_pkg.sv
package ddr_yc_pkg;
  typedef enum logic {
    CHROMA_CB = 1'b0,
    CHROMA_CR = 1'b1
  } chroma_e;

  typedef enum logic {
    ALIGN_RISE = 1'b0,
    ALIGN_FALL = 1'b1
  } align_e;
endpackage

// File: rtl/ddr_edge_capture.sv
module ddr_edge_capture #(
  parameter int unsigned DATA_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] rise_q_o,
  output logic [DATA_W-1:0] rise_d_o,
  output logic [DATA_W-1:0] fall_q_o,
  output logic [DATA_W-1:0] fall_d_o
);
  // rising-edge history: newest and one period older, plus the falling word seen by the last rising edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rise_q_o <= '0;
      rise_d_o <= '0;
      fall_d_o <= '0;
    end else begin
      rise_q_o <= data_i;
      rise_d_o <= rise_q_o;
      fall_d_o <= fall_q_o;
    end
  end

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fall_q_o <= '0;
    else         fall_q_o <= data_i;
  end
endmodule

// File: rtl/trs_phase_tracker.sv
module trs_phase_tracker
  import ddr_yc_pkg::*;
#(
  parameter int unsigned DATA_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [DATA_W-1:0] rise_q_i,
  input  logic [DATA_W-1:0] rise_d_i,
  input  logic [DATA_W-1:0] fall_q_i,
  input  logic [DATA_W-1:0] fall_d_i,
  output align_e            align_o,
  output logic              act_o,
  output logic              locked_o,
  output chroma_e           cr_nxt_o
);
  localparam logic [DATA_W-1:0] PRE_ONES = {DATA_W{1'b1}};
  localparam logic [DATA_W-1:0] PRE_ZERO = '0;

  logic det_rise, det_fall, det_fall_q;

  // chronological order: rise_d, fall_d, rise_q, fall_q
  assign det_rise = (rise_d_i == PRE_ONES) && (fall_d_i == PRE_ZERO) && (rise_q_i == PRE_ZERO);
  assign det_fall = (fall_d_i == PRE_ONES) && (rise_q_i == PRE_ZERO) && (fall_q_i == PRE_ZERO);

  // act marks the edge at which the reference pair is emitted in either alignment
  assign act_o = en_i && (det_rise || det_fall_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      align_o    <= ALIGN_RISE;
      det_fall_q <= 1'b0;
      locked_o   <= 1'b0;
      cr_nxt_o   <= CHROMA_CB;
    end else if (!en_i) begin
      det_fall_q <= 1'b0;
      locked_o   <= 1'b0;
      cr_nxt_o   <= CHROMA_CB;
    end else begin
      det_fall_q <= det_fall && !det_rise;
      if (det_rise)      align_o <= ALIGN_RISE;
      else if (det_fall) align_o <= ALIGN_FALL;
      if (act_o) begin
        locked_o <= 1'b1;
        cr_nxt_o <= CHROMA_CB;
      end else begin
        cr_nxt_o <= (cr_nxt_o == CHROMA_CB) ? CHROMA_CR : CHROMA_CB;
      end
    end
  end
endmodule

// File: rtl/yc_pair_mux.sv
module yc_pair_mux
  import ddr_yc_pkg::*;
#(
  parameter int unsigned DATA_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  align_e            align_i,
  input  logic              locked_i,
  input  chroma_e           cr_nxt_i,
  input  logic [DATA_W-1:0] rise_q_i,
  input  logic [DATA_W-1:0] fall_q_i,
  input  logic [DATA_W-1:0] fall_d_i,
  output logic [DATA_W-1:0] y_o,
  output logic [DATA_W-1:0] c_o,
  output logic              cr_o,
  output logic              valid_o
);
  logic [DATA_W-1:0] c_sel, y_sel;

  always_comb begin
    if (align_i == ALIGN_FALL) begin
      c_sel = fall_d_i;
      y_sel = rise_q_i;
    end else begin
      c_sel = rise_q_i;
      y_sel = fall_q_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      y_o     <= '0;
      c_o     <= '0;
      cr_o    <= 1'b0;
      valid_o <= 1'b0;
    end else begin
      y_o     <= y_sel;
      c_o     <= c_sel;
      cr_o    <= (cr_nxt_i == CHROMA_CR);
      valid_o <= en_i && locked_i;
    end
  end
endmodule

// File: rtl/ddr_yc_deinterleave.sv
module ddr_yc_deinterleave
  import ddr_yc_pkg::*;
#(
  parameter int unsigned DATA_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ddr_en_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] y_o,
  output logic [DATA_W-1:0] c_o,
  output logic              cr_o,
  output logic              valid_o
);
  logic [DATA_W-1:0] rise_q, rise_d, fall_q, fall_d;
  align_e            align;
  logic              trs_act, locked;
  chroma_e           cr_nxt;

  ddr_edge_capture #(.DATA_W(DATA_W)) u_cap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .data_i   (data_i),
    .rise_q_o (rise_q),
    .rise_d_o (rise_d),
    .fall_q_o (fall_q),
    .fall_d_o (fall_d)
  );

  trs_phase_tracker #(.DATA_W(DATA_W)) u_trk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (ddr_en_i),
    .rise_q_i (rise_q),
    .rise_d_i (rise_d),
    .fall_q_i (fall_q),
    .fall_d_i (fall_d),
    .align_o  (align),
    .act_o    (trs_act),
    .locked_o (locked),
    .cr_nxt_o (cr_nxt)
  );

  yc_pair_mux #(.DATA_W(DATA_W)) u_mux (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (ddr_en_i),
    .align_i  (align),
    .locked_i (locked),
    .cr_nxt_i (cr_nxt),
    .rise_q_i (rise_q),
    .fall_q_i (fall_q),
    .fall_d_i (fall_d),
    .y_o      (y_o),
    .c_o      (c_o),
    .cr_o     (cr_o),
    .valid_o  (valid_o)
  );
endmodule

// File: rtl/ddr_yc_deinterleave_chk.sv
module ddr_yc_deinterleave_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic ddr_en_i,
  input logic act_i,
  input logic cr_i,
  input logic valid_i
);
  assert_mode_off_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ddr_en_i |=> !valid_i);

  assert_first_is_cb_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_i) |-> !cr_i);

  assert_cb_after_ref_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_i && ddr_en_i) ##1 ddr_en_i |=> !cr_i);

  assert_flag_toggles_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && $past(valid_i) && !$past(act_i, 2)) |-> (cr_i != $past(cr_i)));
endmodule

bind ddr_yc_deinterleave ddr_yc_deinterleave_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .ddr_en_i (ddr_en_i),
  .act_i    (trs_act),
  .cr_i     (cr_o),
  .valid_i  (valid_o)
);

// File: tb/ddr_yc_deinterleave_tb.sv
module ddr_yc_deinterleave_tb;
  localparam int W = 10;
  localparam int CAP_MAX = 64;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         en = 1'b0;
  logic [W-1:0] data = '0;
  logic [W-1:0] y_o, c_o;
  logic         cr_o, valid_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit next_rise = 1'b1;
  bit rec = 1'b0;
  int cap_n = 0;
  logic [W-1:0] cap_c [CAP_MAX];
  logic [W-1:0] cap_y [CAP_MAX];
  logic         cap_f [CAP_MAX];
  int           cap_t [CAP_MAX];

  always #4 clk = ~clk;

  ddr_yc_deinterleave #(.DATA_W(W)) u_dut (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .ddr_en_i (en),
    .data_i   (data),
    .y_o      (y_o),
    .c_o      (c_o),
    .cr_o     (cr_o),
    .valid_o  (valid_o)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    #2;
    if (rec && valid_o && cap_n < CAP_MAX) begin
      cap_c[cap_n] = c_o;
      cap_y[cap_n] = y_o;
      cap_f[cap_n] = cr_o;
      cap_t[cap_n] = cyc;
      cap_n++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // each word is set 2 ns after the opposite edge and sampled by the next edge
  task automatic send_word(input logic [W-1:0] w);
    if (next_rise) @(negedge clk);
    else           @(posedge clk);
    #2 data = w;
    next_rise = !next_rise;
  endtask

  task automatic send_pre();
    send_word(10'h3FF);
    send_word(10'h000);
    send_word(10'h000);
    send_word(10'h274);
  endtask

  function automatic logic [W-1:0] exp_c(input int k, input int base);
    return (k % 2 == 0) ? W'(12'h100 + base + k / 2) : W'(12'h180 + base + k / 2);
  endfunction

  function automatic logic [W-1:0] exp_y(input int k, input int base);
    return W'(12'h200 + base + k);
  endfunction

  task automatic send_video(input int npairs, input int base);
    for (int k = 0; k < npairs; k++) begin
      send_word(exp_c(k, base));
      send_word(exp_y(k, base));
    end
  endtask

  task automatic do_reset();
    rec = 1'b0;
    en = 1'b0;
    data = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk(valid_o == 1'b0, "R1 valid in reset", valid_o, 0);
    chk(cr_o == 1'b0, "R1 cr in reset", cr_o, 0);
    chk(y_o == '0 && c_o == '0, "R1 data in reset", {y_o, c_o}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    en = 1'b1;
    next_rise = 1'b1;
    @(posedge clk);
    #2;
    chk(valid_o == 1'b0, "R1 valid after release", valid_o, 0);
  endtask

  // compare n captured pairs from index s against video with the given base
  task automatic cmp_video(input int s, input int n, input int base, input string tag);
    chk(cap_n >= s + n, {tag, " pair count"}, cap_n, s + n);
    for (int k = 0; k < n; k++) begin
      if (s + k < cap_n) begin
        chk(cap_c[s+k] == exp_c(k, base), {tag, " R3 chroma word"}, cap_c[s+k], exp_c(k, base));
        chk(cap_y[s+k] == exp_y(k, base), {tag, " R2 luma word"}, cap_y[s+k], exp_y(k, base));
        chk(cap_f[s+k] == 1'(k % 2), {tag, " R4 cb/cr flag"}, cap_f[s+k], k % 2);
        chk(cap_t[s+k] == cap_t[s] + k, {tag, " R10 consecutive valid"}, cap_t[s+k] - cap_t[s], k);
      end
    end
  endtask

  task automatic t_rise_aligned();
    do_reset();
    cap_n = 0;
    rec = 1'b1;
    send_word(10'h0AA);
    send_word(10'h0BB);
    repeat (2) @(posedge clk);
    #2;
    chk(cap_n == 0, "R7 no valid before preamble", cap_n, 0);
    next_rise = 1'b1;
    send_pre();
    send_video(8, 0);
    send_video(2, 8'h30);
    rec = 1'b0;
    cmp_video(0, 8, 0, "R5 rise-aligned");
  endtask

  task automatic t_fall_aligned();
    do_reset();
    cap_n = 0;
    rec = 1'b1;
    send_word(10'h111);
    send_pre();
    send_video(8, 8'h10);
    send_video(2, 8'h30);
    rec = 1'b0;
    cmp_video(0, 8, 8'h10, "R6 fall-aligned");
  endtask

  task automatic t_realign();
    int idx;
    do_reset();
    send_pre();
    send_video(4, 0);
    cap_n = 0;
    rec = 1'b1;
    send_word(10'h155);
    send_pre();
    send_video(8, 8'h20);
    send_video(2, 8'h30);
    rec = 1'b0;
    idx = -1;
    for (int i = 0; i < cap_n; i++)
      if (idx < 0 && cap_c[i] == exp_c(0, 8'h20) && cap_y[i] == exp_y(0, 8'h20)) idx = i;
    chk(idx >= 0 && idx <= 5, "R8 realign within one preamble", idx, 5);
    if (idx >= 0) cmp_video(idx, 8, 8'h20, "R8 after slip");
  endtask

  task automatic t_mode_toggle();
    do_reset();
    send_pre();
    send_video(4, 0);
    en = 1'b0;
    @(posedge clk);
    #3;
    chk(valid_o == 1'b0, "R9 valid drops with enable", valid_o, 0);
    cap_n = 0;
    rec = 1'b1;
    send_video(4, 8'h05);
    chk(cap_n == 0, "R9 no pairs while disabled", cap_n, 0);
    en = 1'b1;
    send_video(6, 8'h06);
    chk(cap_n == 0, "R9 no pairs before new preamble", cap_n, 0);
    send_pre();
    send_video(8, 8'h08);
    send_video(2, 8'h30);
    rec = 1'b0;
    cmp_video(0, 8, 8'h08, "R9 relock");
  endtask

  initial begin
    #(8 * 100000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_rise_aligned();
    t_fall_aligned();
    t_realign();
    t_mode_toggle();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule